// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Unlock Sequencer

This block is the device side of a pseudo-SRAM model on an asynchronous memory bus. Every access is the span during which chip enable is held low, and the block acts on it when chip enable returns high. Most accesses are ordinary reads and writes to a small behavioural word array. A fixed chain of six accesses replaces the old configuration word:

1. a read of the highest bus address;
2. two writes that return the word just read to that address;
3. two writes to that address whose data is ignored;
4. a final read whose low address bits carry the new mode key.

The block follows the chain and drops it as soon as an access breaks the pattern. Some breaking accesses are then served as plain accesses and some are discarded. If the key changes the configuration, the array contents become invalid. The model shows this by making every word read as a fixed fill pattern.

The bus side is sampled on a system clock, which suits a simulation model or a logic-based stand-in for the memory. Only the low bits of the address select an array word, so the array stays small while the full bus address is decoded for the unlock chain.

Top module: `psram_cfg_unlock`

## Requirements
- R1: After reset `cfg` equals CFG_DEFAULT (8'h10). Bit 0 = 0 selects asynchronous page-read / normal-write operation, and bits [5:4] = 2'b01 select the sleep power-down option. Every array word reads as FILL_WORD (16'hA5A5) until it is written.
- R2: An access is one unbroken span of `ce_n` low. It counts as a write if `we_n` was low in any of its cycles, even if only in a later cycle. It takes effect on the cycle `ce_n` returns high. The address and data used are those of its last low cycle.
- R3: A plain write stores `din` at array word `addr[ARRAY_AW-1:0]`. During a read with `oe_n` low, `dout` shows that word from the second clock of the access on. Outside a read, `dout` is 0.
- R4: From idle, a read of the all-ones address starts the chain, and the word it returns is remembered.
- R5: Accesses 2 and 3 must be writes to the all-ones address with data equal to the remembered word. Such a write is also stored. Any other write at these positions ends the chain and is stored as a plain write.
- R6: Accesses 4 and 5 must be writes to the all-ones address. Their data is ignored and not stored. A write to any other address at these positions ends the chain and is discarded.
- R7: A read at positions 2 to 5 ends the chain and is served as a plain read. An access that ends a chain never starts a new one.
- R8: A read at position 6 completes the chain and loads `cfg` from `addr[CFG_W-1:0]`. A write at position 6 ends the chain and is stored as a plain write.
- R9: If the loaded key differs from the previous `cfg`, every array word reads FILL_WORD until it is rewritten. An equal key leaves the array intact.
- R10: `cfg` changes only on the clock that completes a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; frames each access |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (23) | Bus address |
| din | input | DATA_W (16) | Write data |
| dout | output | DATA_W (16) | Read data, 0 when not reading |
| cfg | output | CFG_W (8) | Configuration word |

## Verification
The bench builds the block with its default parameters. Because a 64-word array sits behind a full 23-bit address, the whole array can be refilled and read back after every scenario. The bench breaks the unlock chain at each of the six positions with each kind of wrong access: a read, a write to another address, and a write of wrong data. A reference model kept in the bench decides, for each case, which writes must land and whether the configuration and the fill pattern change. Complete chains with a changing key and with an unchanged key, and a write whose enable falls late in the access, complete the set.

// File: rtl/psram_unlock_pkg.sv
package psram_unlock_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WB1  = 3'd1,
    S_WB2  = 3'd2,
    S_DC1  = 3'd3,
    S_DC2  = 3'd4,
    S_KEY  = 3'd5
  } step_t;
endpackage

// File: rtl/bus_frame_tracker.sv
module bus_frame_tracker #(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          acc_end,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_din
);
  logic ce_act_q;
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_act_q <= 1'b0;
      wr_q     <= 1'b0;
      acc_addr <= '0;
      acc_din  <= '0;
    end else begin
      ce_act_q <= ~ce_n;
      if (!ce_n) begin
        acc_addr <= addr;
        acc_din  <= din;
        wr_q     <= ce_act_q ? (wr_q | ~we_n) : ~we_n;
      end
    end
  end

  assign acc_end = ce_act_q & ce_n;
  assign acc_wr  = wr_q;

  // R2: an access only ends right after a cycle with chip enable low
  a_r2_end_framing: assert property (@(posedge clk) disable iff (rst)
    acc_end |-> $past(!ce_n));
endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
  import psram_unlock_pkg::*;
#(
  parameter int            AW          = 23,
  parameter int            DW          = 16,
  parameter int            CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_end,
  input  logic             acc_wr,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_din,
  input  logic [DW-1:0]    rd_word,
  output logic             wr_commit,
  output logic             wipe,
  output logic [CFG_W-1:0] cfg
);
  step_t            step_q, step_nxt;
  logic [DW-1:0]    rda_q;
  logic [CFG_W-1:0] cfg_q;
  logic             load;
  logic             is_top;
  logic             wb_ok;
  logic [CFG_W-1:0] key;

  assign is_top = (acc_addr == {AW{1'b1}});
  assign wb_ok  = acc_wr & is_top & (acc_din == rda_q);
  assign key    = acc_addr[CFG_W-1:0];

  always_comb begin
    step_nxt  = step_q;
    wr_commit = 1'b0;
    load      = 1'b0;
    if (acc_end) begin
      unique case (step_q)
        S_IDLE: begin
          wr_commit = acc_wr;
          if (!acc_wr && is_top) step_nxt = S_WB1;
        end
        S_WB1: begin
          wr_commit = acc_wr;
          step_nxt  = wb_ok ? S_WB2 : S_IDLE;
        end
        S_WB2: begin
          wr_commit = acc_wr;
          step_nxt  = wb_ok ? S_DC1 : S_IDLE;
        end
        S_DC1: step_nxt = (acc_wr && is_top) ? S_DC2 : S_IDLE;
        S_DC2: step_nxt = (acc_wr && is_top) ? S_KEY : S_IDLE;
        S_KEY: begin
          wr_commit = acc_wr;
          load      = ~acc_wr;
          step_nxt  = S_IDLE;
        end
        default: step_nxt = S_IDLE;
      endcase
    end
  end

  assign wipe = load & (key != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= S_IDLE;
      rda_q  <= '0;
      cfg_q  <= CFG_DEFAULT;
    end else begin
      step_q <= step_nxt;
      if (acc_end && step_q == S_IDLE && !acc_wr && is_top) rda_q <= rd_word;
      if (load) cfg_q <= key;
    end
  end

  assign cfg = cfg_q;

  // R10: configuration only moves on the clock after an access ends
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_end) |-> $stable(cfg_q));
  // R4: a top-address read from idle opens the chain
  a_r4_start: assert property (@(posedge clk) disable iff (rst)
    (acc_end && step_q == S_IDLE && !acc_wr && is_top) |=> step_q == S_WB1);
  // R7: a read in the middle of the chain returns to idle
  a_r7_read_abort: assert property (@(posedge clk) disable iff (rst)
    (acc_end && !acc_wr && step_q != S_IDLE && step_q != S_KEY) |=> step_q == S_IDLE);
  // R6: the ignored-data writes never reach the array
  a_r6_no_store: assert property (@(posedge clk) disable iff (rst)
    (step_q == S_DC1 || step_q == S_DC2) |-> !wr_commit);
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int            DW        = 16,
  parameter int            IAW       = 6,
  parameter logic [DW-1:0] FILL_WORD = 16'hA5A5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           oe,
  input  logic [IAW-1:0] rd_idx,
  input  logic           wr_en,
  input  logic [IAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           wipe,
  output logic [DW-1:0]  rd_word,
  output logic [DW-1:0]  dout
);
  localparam int DEPTH = 1 << IAW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    mem_q;
  logic [DEPTH-1:0] stale;
  logic             stale_q;
  logic             oe_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stale   <= '1;
      stale_q <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      if (wipe) stale <= '1;
      else if (wr_en) stale[wr_idx] <= 1'b0;
      if (rd_en) stale_q <= stale[rd_idx];
      oe_q <= rd_en & oe;
    end
  end

  assign rd_word = stale_q ? FILL_WORD : mem_q;
  assign dout    = oe_q ? rd_word : '0;

  // R9: a wipe marks every word invalid
  a_r9_fill_all: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (&stale));
endmodule

// File: rtl/psram_cfg_unlock.sv
module psram_cfg_unlock #(
  parameter int               ADDR_W      = 23,
  parameter int               DATA_W      = 16,
  parameter int               ARRAY_AW    = 6,
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h10,
  parameter logic [DATA_W-1:0] FILL_WORD  = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CFG_W-1:0]  cfg
);
  logic              acc_end, acc_wr, wr_commit, wipe;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_din, rd_word;

  bus_frame_tracker #(.AW(ADDR_W), .DW(DATA_W)) u_trk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .acc_end(acc_end), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_din(acc_din)
  );

  unlock_seq #(.AW(ADDR_W), .DW(DATA_W), .CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_seq (
    .clk(clk), .rst(rst), .acc_end(acc_end), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_din(acc_din), .rd_word(rd_word), .wr_commit(wr_commit), .wipe(wipe), .cfg(cfg)
  );

  psram_array #(.DW(DATA_W), .IAW(ARRAY_AW), .FILL_WORD(FILL_WORD)) u_arr (
    .clk(clk), .rst(rst), .rd_en(~ce_n & we_n), .oe(~oe_n),
    .rd_idx(addr[ARRAY_AW-1:0]), .wr_en(wr_commit), .wr_idx(acc_addr[ARRAY_AW-1:0]),
    .wr_data(acc_din), .wipe(wipe), .rd_word(rd_word), .dout(dout)
  );
endmodule

// File: tb/tb_psram_cfg_unlock.sv
module tb_psram_cfg_unlock;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] TOP  = 23'h7FFFFF;
  localparam logic [15:0] FILL = 16'hA5A5;

  logic clk = 0, rst = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [22:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [7:0]  cfg;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] ref_mem [64];
  bit          ref_stale [64];
  int          ref_step = 0;
  logic [15:0] ref_rda = '0;
  logic [7:0]  ref_cfg = 8'h10;

  psram_cfg_unlock dut (.clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
                        .addr(addr), .din(din), .dout(dout), .cfg(cfg));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_store(input logic [22:0] a, input logic [15:0] d);
    ref_mem[a[5:0]] = d;
    ref_stale[a[5:0]] = 0;
  endfunction

  function automatic logic [15:0] ref_read(input logic [22:0] a);
    logic [15:0] v = ref_stale[a[5:0]] ? FILL : ref_mem[a[5:0]];
    if (ref_step == 0) begin
      if (a == TOP) begin ref_rda = v; ref_step = 1; end
    end else if (ref_step < 5) begin
      ref_step = 0;
    end else begin
      ref_step = 0;
      if (a[7:0] != ref_cfg) begin
        ref_cfg = a[7:0];
        for (int i = 0; i < 64; i++) ref_stale[i] = 1;
      end
    end
    return v;
  endfunction

  function automatic void ref_write(input logic [22:0] a, input logic [15:0] d);
    case (ref_step)
      0: ref_store(a, d);
      1, 2: begin
        ref_store(a, d);
        ref_step = (a == TOP && d == ref_rda) ? ref_step + 1 : 0;
      end
      3, 4: ref_step = (a == TOP) ? ref_step + 1 : 0;
      default: begin ref_store(a, d); ref_step = 0; end
    endcase
  endfunction

  task automatic bus_read(input logic [22:0] a, input bit chk, input string req);
    logic [15:0] exp;
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = a;
    @(negedge clk);
    @(negedge clk);
    exp = ref_read(a);
    if (chk) check(dout === exp, req, {16'h0, dout}, {16'h0, exp});
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    if (chk) check(dout === 16'h0, "R3 idle dout", {16'h0, dout}, 32'h0);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [22:0] a, input logic [15:0] d, input bit late);
    @(negedge clk); ce_n = 0; we_n = late; addr = a; din = d;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
    ref_write(a, d);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic refill(input int seed);
    for (int i = 0; i < 64; i++) bus_write({17'h0, 6'(i)}, 16'(i * 37 + seed * 101), 0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 64; i++) bus_read({17'h0, 6'(i)}, 1, req);
  endtask

  // kind 0: read of TOP, 1: write elsewhere, 2: write TOP with wrong data
  task automatic chain(input logic [7:0] key, input int brk, input int kind);
    for (int k = 0; k < 6; k++) begin
      if (k == brk) begin
        case (kind)
          0: bus_read(TOP, 1, "R7 breaking read");
          1: bus_write(23'h000107, 16'h7700 + 16'(k), 0);
          default: bus_write(TOP, ref_rda ^ 16'h0001, 0);
        endcase
      end else if (k == 0) bus_read(TOP, 1, "R4 chain opening read");
      else if (k < 3) bus_write(TOP, ref_rda, 0);
      else if (k < 5) bus_write(TOP, 16'hBEEF ^ 16'(k), 0);
      else bus_read({15'h12, key}, 0, "R8");
    end
    @(negedge clk);
    check(cfg === ref_cfg, "R8 R10 cfg after chain", {24'h0, cfg}, {24'h0, ref_cfg});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin ref_mem[i] = '0; ref_stale[i] = 1; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cfg === 8'h10, "R1 reset cfg", {24'h0, cfg}, 32'h10);
    check(dout === 16'h0, "R1 reset dout", {16'h0, dout}, 32'h0);
    bus_read(23'h000005, 1, "R1 unwritten word");
    bus_read(TOP - 23'd1, 1, "R1 unwritten word");
    refill(0);
    sweep("R3 plain write/read");
    bus_write(23'h000009, 16'h1234, 1);
    bus_read(23'h000009, 1, "R2 late write enable");
    // full chain with a new key: array wiped
    chain(8'h3C, 99, 0);
    sweep("R9 wipe after new key");
    // same key again: array retained
    refill(1);
    chain(8'h3C, 99, 0);
    sweep("R9 same key keeps array");
    // break the chain at every position with every kind of wrong access
    for (int brk = 0; brk < 6; brk++) begin
      for (int kind = 0; kind < 3; kind++) begin
        refill(brk * 3 + kind + 2);
        chain(8'h40 + 8'(brk * 3 + kind), brk, kind);
        sweep("R5 R6 R7 R8 array after broken chain");
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule